// File: doc/BRIEF.md
# Word to Halfword/Byte Transmit Unpacker

This block takes 36-bit words from a buffer and hands them to an 18-bit transmit port. Each word is split into smaller parts. In halfword size a word leaves as two 18-bit transfers. In byte size it leaves as four 9-bit transfers on the low nine output lines, with the upper nine lines held at zero. An ordering control picks which end of the word goes out first: the most significant part first, or the least significant part first.

Both sides use a valid/ready handshake, and a transfer happens on a rising clock edge where valid and ready are both high. The block holds one word at a time. It does not take a new word until the last part of the current word has been accepted downstream. The size and ordering inputs are captured together with each word, so changing them in the middle of a word has no effect until the next word.

Top module: `word_unpacker`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0, in_ready_o is 1 and out_data_o is 0.
- R2: in_ready_o is 1 exactly when no word is held. A word is captured on the edge where in_valid_i and in_ready_o are both 1. After that edge out_valid_o is 1 and in_ready_o is 0.
- R3: With byte_mode_i=0 and little_endian_i=0, a word goes out as two transfers: bits 35:18 first, then bits 17:0.
- R4: With byte_mode_i=0 and little_endian_i=1, a word goes out as two transfers: bits 17:0 first, then bits 35:18.
- R5: With byte_mode_i=1 and little_endian_i=0, a word goes out as four transfers on out_data_o[8:0], in the order 35:27, 26:18, 17:9, 8:0. During these transfers out_data_o[17:9] is 0.
- R6: With byte_mode_i=1 and little_endian_i=1, the four byte transfers go out in the order 8:0, 17:9, 26:18, 35:27, with out_data_o[17:9] at 0.
- R7: A part moves on only on an edge where out_ready_i is 1. While out_valid_o is 1 and out_ready_i is 0, out_data_o and out_valid_o hold.
- R8: byte_mode_i and little_endian_i are used only on the capture edge. Changing them while a word is in progress does not change that word's remaining transfers.
- R9: Pulling rst_ni low in the middle of a word throws away the parts not yet sent and returns the block to idle.
- R10: in_valid_i and in_data_i are ignored while a word is held. The offered word is captured only after the current word's last transfer, and the current word's parts are not changed.
- R11: out_data_o is 0 whenever out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_mode_i | input | 1 | 1 selects byte size, 0 selects halfword size |
| little_endian_i | input | 1 | 1 sends the least significant part first |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Block can take a word |
| in_data_i | input | 36 | Input word |
| out_valid_o | output | 1 | Output part valid |
| out_ready_i | input | 1 | Downstream takes the part |
| out_data_o | output | 18 | Output part, zero-extended in byte size |

## Verification
A word captured on edge k puts its first part on out_data_o right after that edge. Each later part appears one edge after the previous part was taken. in_ready_o comes back after the edge that takes the last part, so the next capture can happen one edge later at the earliest. The bench drives inputs on the falling edge and samples everything 2 ns after it. At that point it knows whether the next rising edge will transfer, and it pops the expected part for that edge. Random output stalls check that the held data stays put and that the order does not depend on timing.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned PORT_W = 18;
  localparam int unsigned LANE_W = 9;

  typedef struct packed {
    logic byte_mode;
    logic lsb_first;
  } unpack_cfg_t;
endpackage

// File: rtl/unpack_cfg.sv
module unpack_cfg
  import unpack_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  unpack_cfg_t cfg_i,
  output unpack_cfg_t cfg_o
);
  unpack_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/unpack_seq.sv
module unpack_seq #(
  parameter int unsigned N_HALF = 2,
  parameter int unsigned N_LANE = 4,
  localparam int unsigned IDX_W = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             take_i,
  input  logic             byte_mode_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(N_HALF - 1);
  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(N_LANE - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = byte_mode_i ? LAST_LANE : LAST_HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (take_i) begin
      if (idx_q == last_idx) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/unpack_sel.sv
module unpack_sel #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned PORT_W = 18,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned N_HALF = WORD_W / PORT_W,
  localparam int unsigned N_LANE = WORD_W / LANE_W,
  localparam int unsigned IDX_W  = (N_LANE > 1) ? $clog2(N_LANE) : 1,
  localparam int unsigned HSEL_W = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              busy_i,
  input  logic              byte_mode_i,
  input  logic              lsb_first_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PORT_W-1:0] data_o
);
  logic [WORD_W-1:0] word_q;
  logic [PORT_W-1:0] halves [N_HALF];
  logic [LANE_W-1:0] lanes  [N_LANE];
  logic [HSEL_W-1:0] hsel;
  logic [IDX_W-1:0]  lsel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign halves[h] = word_q[h*PORT_W +: PORT_W];
  end

  for (genvar b = 0; b < N_LANE; b++) begin : g_lane
    assign lanes[b] = word_q[b*LANE_W +: LANE_W];
  end

  // part index counts transfers; segment index counts from bit 0
  assign hsel = lsb_first_i ? idx_i[HSEL_W-1:0]
                            : HSEL_W'(N_HALF - 1) - idx_i[HSEL_W-1:0];
  assign lsel = lsb_first_i ? idx_i : IDX_W'(N_LANE - 1) - idx_i;

  always_comb begin
    data_o = '0;
    if (busy_i) begin
      if (byte_mode_i) data_o = PORT_W'(lanes[lsel]);
      else             data_o = halves[hsel];
    end
  end
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker
  import unpack_pkg::*;
#(
  parameter int unsigned IN_W   = WORD_W,
  parameter int unsigned OUT_W  = PORT_W,
  parameter int unsigned BYTE_W = LANE_W,
  localparam int unsigned N_HALF = IN_W / OUT_W,
  localparam int unsigned N_LANE = IN_W / BYTE_W,
  localparam int unsigned IDX_W  = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_mode_i,
  input  logic             little_endian_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o
);
  logic             busy;
  logic             load;
  logic             take;
  logic [IDX_W-1:0] idx;
  unpack_cfg_t      cfg_in;
  unpack_cfg_t      cfg_q;
  logic             cfg_byte;

  assign load     = in_valid_i && !busy;
  assign take     = busy && out_ready_i;
  assign cfg_in   = '{byte_mode: byte_mode_i, lsb_first: little_endian_i};
  assign cfg_byte = cfg_q.byte_mode;

  unpack_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  unpack_seq #(
    .N_HALF (N_HALF),
    .N_LANE (N_LANE)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .take_i      (take),
    .byte_mode_i (cfg_q.byte_mode),
    .busy_o      (busy),
    .idx_o       (idx)
  );

  unpack_sel #(
    .WORD_W (IN_W),
    .PORT_W (OUT_W),
    .LANE_W (BYTE_W)
  ) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .word_i      (in_data_i),
    .busy_i      (busy),
    .byte_mode_i (cfg_q.byte_mode),
    .lsb_first_i (cfg_q.lsb_first),
    .idx_i       (idx),
    .data_o      (out_data_o)
  );

  assign in_ready_o  = !busy;
  assign out_valid_o = busy;
endmodule

// File: rtl/unpack_chk.sv
module unpack_chk #(
  parameter int unsigned OUT_W  = 18,
  parameter int unsigned BYTE_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             cfg_byte
);
  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && !in_ready_o));

  // R2
  no_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cfg_byte) |-> (out_data_o[OUT_W-1:BYTE_W] == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == '0));
endmodule

bind word_unpacker unpack_chk #(
  .OUT_W  (OUT_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .cfg_byte    (cfg_byte)
);

// File: tb/tb_word_unpacker.sv
`timescale 1ns/1ps
module tb_word_unpacker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic        little_endian_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [35:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [17:0] out_data_o;

  int checks = 0;
  int fails = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [17:0] exp_q [$];
  string       tag_q [$];
  bit          stall_prev = 1'b0;
  logic [17:0] stall_data = '0;

  always #10 clk = ~clk;

  word_unpacker dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .byte_mode_i     (byte_mode_i),
    .little_endian_i (little_endian_i),
    .in_valid_i      (in_valid_i),
    .in_ready_o      (in_ready_o),
    .in_data_i       (in_data_i),
    .out_valid_o     (out_valid_o),
    .out_ready_i     (out_ready_i),
    .out_data_o      (out_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // downstream ready pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = lfsr[0];
      default: out_ready_i = 1'b0;
    endcase
  end

  // monitor: sample after the falling edge; a transfer fires at the next rising edge
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_ni) begin
      if (stall_prev) chk(out_valid_o && out_data_o == stall_data, "R7", 36'(out_data_o), 36'(stall_data));
      stall_prev = out_valid_o && !out_ready_i;
      stall_data = out_data_o;
      if (!out_valid_o) chk(out_data_o == '0, "R11", 36'(out_data_o), 36'd0);
      chk(!(in_ready_o && out_valid_o), "R2", {34'd0, in_ready_o, out_valid_o}, 36'd0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected part", 36'(out_data_o), 36'd0);
        end else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data_o == e, t, 36'(out_data_o), 36'(e));
        end
      end
    end
  end

  task automatic send_word(input logic [35:0] w, input bit bm, input bit le, input string extra);
    string base;
    if (bm) base = le ? "R6" : "R5";
    else    base = le ? "R4" : "R3";
    if (!bm) begin
      if (le) begin exp_q.push_back(w[17:0]);  exp_q.push_back(w[35:18]); end
      else    begin exp_q.push_back(w[35:18]); exp_q.push_back(w[17:0]);  end
      repeat (2) tag_q.push_back({extra, base});
    end else begin
      for (int p = 0; p < 4; p++) begin
        int s;
        s = le ? p : 3 - p;
        exp_q.push_back({9'd0, w[s*9 +: 9]});
        tag_q.push_back({extra, base});
      end
    end
    @(negedge clk);
    in_valid_i      = 1'b1;
    in_data_i       = w;
    byte_mode_i     = bm;
    little_endian_i = le;
    forever begin
      #2;
      if (in_ready_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid_i      = 1'b0;
    in_data_i       = ~w;
    // R8: settings flipped mid-word must not alter the remaining parts
    byte_mode_i     = ~bm;
    little_endian_i = ~le;
    #2;
    chk(out_valid_o && !in_ready_o, "R2 capture", {34'd0, out_valid_o, in_ready_o}, 36'd2);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1
    chk(out_valid_o == 1'b0, "R1 valid", 36'(out_valid_o), 36'd0);
    chk(in_ready_o == 1'b1, "R1 ready", 36'(in_ready_o), 36'd1);
    chk(out_data_o == '0, "R1 data", 36'(out_data_o), 36'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    rdy_mode = 0;
    send_word(36'h9_ABCD_1234, 1'b0, 1'b0, "");
    send_word(36'h1_2345_6789, 1'b0, 1'b1, "");
    send_word(36'hF_EDCB_A987, 1'b1, 1'b0, "");
    send_word(36'h8_0402_0100, 1'b1, 1'b1, "");
    drain();

    rdy_mode = 1;
    for (int i = 0; i < 24; i++) begin
      logic [35:0] w;
      w = {lfsr[3:0], lfsr, ~lfsr} ^ 36'(i * 36'h1_1111_1111);
      send_word(w, i[0], i[1], "R8 ");
    end
    drain();

    // R10: next word offered while current one is held
    rdy_mode = 1;
    send_word(36'hA_AAAA_5555, 1'b1, 1'b0, "R10 ");
    send_word(36'h5_5555_AAAA, 1'b0, 1'b1, "R10 ");
    send_word(36'h0_0000_0001, 1'b1, 1'b1, "R10 ");
    drain();

    // R9: reset in the middle of a word
    rdy_mode = 2;
    send_word(36'hC_0FFE_E123, 1'b1, 1'b0, "R9 ");
    @(negedge clk);
    #5;
    rst_ni = 1'b0;
    exp_q.delete();
    tag_q.delete();
    stall_prev = 1'b0;
    @(negedge clk);
    #2;
    chk(out_valid_o == 1'b0, "R9 valid", 36'(out_valid_o), 36'd0);
    chk(in_ready_o == 1'b1, "R9 ready", 36'(in_ready_o), 36'd1);
    chk(out_data_o == '0, "R9 data", 36'(out_data_o), 36'd0);
    rdy_mode = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    send_word(36'h3_1415_9265, 1'b0, 1'b0, "R9 ");
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule